// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset requests into one internal reset for a small controller core. The requests are an external reset pad pulled low from outside, a supply-low level from a low-voltage detector, and a one-cycle underflow pulse from a watchdog timer. Whatever the trigger, the block runs the same fixed sequence. First comes an active phase whose length depends on the trigger. Then comes a stabilisation delay of 256 or 4096 core clocks, chosen by an option bit. Last comes a two-cycle fetch of the reset vector.

The reset pad is bidirectional and open-drain. The block reads the pad level through a two-flop synchroniser and a minimum-width filter. It also drives a pull-down enable, so that other devices on the board see the reset too. The pull-down is on for the whole delay phase. A new request in any phase restarts the sequence from the active phase. A two-bit code reports which source caused the most recent reset.

Top module: `rst_sequencer`

## Requirements
- R1: After the block's own power-up reset (porN low), coreRst is 1, padPullDown is 1 and resetCause is 2'b10. On release the block finishes a full sequence with cause 2'b10.
- R2: Every sequence runs the active phase, then the delay phase, then the fetch phase. coreRst is 1 during the active and delay phases and 0 during fetch and normal run.
- R3: The delay phase lasts 256 cycles when longDelay is 0 and 4096 cycles when it is 1. The option is sampled on the cycle the delay phase begins, so later changes do not alter that delay.
- R4: The fetch phase lasts exactly 2 cycles with vecFetch at 1. vecAddr is 16'hFFFE in the first cycle and 16'hFFFF in the second.
- R5: padPullDown is 1 in every cycle of the delay phase, whatever the cause. It is 0 during fetch and normal run.
- R6: A low pad level is taken as an external request only after it has been seen low for at least 4 consecutive synchronised cycles. A shorter low pulse starts no sequence. An external request sets resetCause to 2'b00.
- R7: In the active phase of an external reset, the block does not pull the pad down. The active phase lasts until the synchronised pad level returns high.
- R8: A watchdog underflow pulse sets resetCause to 2'b01. It gives a 16-cycle active phase with padPullDown at 1, so the pad is held low for 16 cycles plus the delay.
- R9: While lvdLow is 1, the block stays in the active phase with padPullDown at 1 and resetCause 2'b10. The delay phase starts on the cycle after lvdLow returns to 0.
- R10: A request in any phase restarts the sequence from the active phase. When requests arrive together, the priority is: low-voltage first, then watchdog, then external.
- R11: resetCause keeps the value of the last accepted request after the sequence ends, until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porN | input | 1 | Asynchronous power-up reset of the block itself, active low |
| padIn | input | 1 | Level read back from the reset pad (0 = low) |
| lvdLow | input | 1 | Supply-low level from the voltage detector |
| wdgUnder | input | 1 | One-cycle watchdog underflow pulse |
| longDelay | input | 1 | Delay option: 0 selects 256 cycles, 1 selects 4096 cycles |
| padPullDown | output | 1 | Enables the open-drain pull-down on the reset pad |
| coreRst | output | 1 | Internal reset to the core, active high |
| vecFetch | output | 1 | High during the two reset-vector fetch cycles |
| vecAddr | output | 16 | Reset-vector byte address during fetch |
| resetCause | output | 2 | 00 external, 01 watchdog, 10 low-voltage |

## Verification
The assertions assume the following about the inputs:
- wdgUnder is a single-cycle pulse.
- lvdLow and the pad change only between clock edges.
- The pad is low only when the outside pulls it low or when padPullDown is on.

The stimulus keeps to these rules. All inputs are driven on the falling clock edge. The watchdog strobe is raised for exactly one cycle. The pad is modelled as a wired-AND of the bench's own pull-down and the block's pull-down, so it is never forced high. Expected phase lengths come from the request timing. For an external pulse of K cycles, the sequence is held in reset for K-3 active cycles plus the delay.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    CAUSE_EXT = 2'b00,
    CAUSE_WDG = 2'b01,
    CAUSE_LVD = 2'b10
  } causeT;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_DELAY  = 2'd2,
    PH_FETCH  = 2'd3
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic latchDly;
  } strobeT;

endpackage

// File: rtl/rst_seq_dpath.sv
module rst_seq_dpath
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EXT_MIN_CYC = 4,
  parameter int WDG_PULSE_CYC = 16,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG = 4096,
  parameter int FETCH_CYC = 2,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              padIn,
  input  logic              maskExt,
  input  logic              longDelay,
  input  strobeT            strobe,
  output logic              pinLowSync,
  output logic              extReq,
  output logic              pulseDone,
  output logic              dlyDone,
  output logic              fetchDone,
  output logic [ADDR_W-1:0] vecAddr
);

  localparam int MAX_A = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int MAX_LEN = (MAX_A > WDG_PULSE_CYC) ? MAX_A : WDG_PULSE_CYC;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int EXT_W = $clog2(EXT_MIN_CYC + 1);

  // pad synchroniser, idles high
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end
  assign pinLowSync = ~syncQ[SYNC_STAGES-1];

  // minimum-width filter for the external request
  logic [EXT_W-1:0] extCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                   extCnt <= '0;
    else if (!pinLowSync || maskExt)             extCnt <= '0;
    else if (extCnt != EXT_W'(EXT_MIN_CYC))      extCnt <= extCnt + EXT_W'(1);
  end
  assign extReq = pinLowSync && !maskExt && (extCnt == EXT_W'(EXT_MIN_CYC - 1));

  // shared phase counter
  logic [CNT_W-1:0] seqCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              seqCnt <= '0;
    else if (strobe.cntClr) seqCnt <= '0;
    else if (strobe.cntInc) seqCnt <= seqCnt + CNT_W'(1);
  end

  // delay length captured when the delay phase starts
  logic [CNT_W-1:0] dlyLenQ;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                dlyLenQ <= CNT_W'(DLY_SHORT);
    else if (strobe.latchDly) dlyLenQ <= longDelay ? CNT_W'(DLY_LONG) : CNT_W'(DLY_SHORT);
  end

  assign pulseDone = (seqCnt == CNT_W'(WDG_PULSE_CYC - 1));
  assign dlyDone   = (seqCnt == dlyLenQ - CNT_W'(1));
  assign fetchDone = (seqCnt == CNT_W'(FETCH_CYC - 1));
  assign vecAddr   = VEC_ADDR + ADDR_W'(seqCnt);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   porN,
  input  logic   lvdLow,
  input  logic   wdgUnder,
  input  logic   extReq,
  input  logic   pinLowSync,
  input  logic   pulseDone,
  input  logic   dlyDone,
  input  logic   fetchDone,
  output strobeT strobe,
  output logic   coreRst,
  output logic   padPullDown,
  output logic   vecFetch,
  output causeT  causeQ
);

  phaseT phaseQ, nextPhase;
  causeT nextCause;

  always_comb begin
    nextPhase = phaseQ;
    nextCause = causeQ;
    strobe    = '0;
    if (lvdLow) begin
      nextPhase = PH_ACTIVE; nextCause = CAUSE_LVD; strobe.cntClr = 1'b1;
    end else if (wdgUnder) begin
      nextPhase = PH_ACTIVE; nextCause = CAUSE_WDG; strobe.cntClr = 1'b1;
    end else if (extReq) begin
      nextPhase = PH_ACTIVE; nextCause = CAUSE_EXT; strobe.cntClr = 1'b1;
    end else begin
      case (phaseQ)
        PH_ACTIVE: begin
          if (causeQ == CAUSE_WDG) begin
            if (pulseDone) begin
              nextPhase = PH_DELAY; strobe.cntClr = 1'b1; strobe.latchDly = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end else if (causeQ == CAUSE_EXT) begin
            if (!pinLowSync) begin
              nextPhase = PH_DELAY; strobe.cntClr = 1'b1; strobe.latchDly = 1'b1;
            end
          end else begin
            nextPhase = PH_DELAY; strobe.cntClr = 1'b1; strobe.latchDly = 1'b1;
          end
        end
        PH_DELAY: begin
          if (dlyDone) begin
            nextPhase = PH_FETCH; strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        PH_FETCH: begin
          if (fetchDone) begin
            nextPhase = PH_RUN; strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: nextPhase = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phaseQ <= PH_ACTIVE;
      causeQ <= CAUSE_LVD;
    end else begin
      phaseQ <= nextPhase;
      causeQ <= nextCause;
    end
  end

  assign coreRst     = (phaseQ == PH_ACTIVE) || (phaseQ == PH_DELAY);
  assign padPullDown = (phaseQ == PH_DELAY) || ((phaseQ == PH_ACTIVE) && (causeQ != CAUSE_EXT));
  assign vecFetch    = (phaseQ == PH_FETCH);

  // R4: fetch never exceeds two cycles
  a_r4_fetch_len: assert property (@(posedge clk) disable iff (!porN)
    vecFetch && $past(vecFetch) |=> !vecFetch);

  // R5: fetch is always preceded by a pulled-down delay cycle
  a_r5_delay_pulled: assert property (@(posedge clk) disable iff (!porN)
    $rose(vecFetch) |-> $past(padPullDown) && !$past(vecFetch));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EXT_MIN_CYC = 4,
  parameter int WDG_PULSE_CYC = 16,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG = 4096,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              padIn,
  input  logic              lvdLow,
  input  logic              wdgUnder,
  input  logic              longDelay,
  output logic              padPullDown,
  output logic              coreRst,
  output logic              vecFetch,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [1:0]        resetCause
);

  localparam int FETCH_CYC = 2;

  strobeT strobe;
  causeT  causeQ;
  logic   pinLowSync, extReq, pulseDone, dlyDone, fetchDone;

  rst_seq_dpath #(
    .SYNC_STAGES(SYNC_STAGES), .EXT_MIN_CYC(EXT_MIN_CYC), .WDG_PULSE_CYC(WDG_PULSE_CYC),
    .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG), .FETCH_CYC(FETCH_CYC),
    .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
  ) uDpath (
    .clk(clk), .porN(porN), .padIn(padIn), .maskExt(padPullDown), .longDelay(longDelay),
    .strobe(strobe), .pinLowSync(pinLowSync), .extReq(extReq), .pulseDone(pulseDone),
    .dlyDone(dlyDone), .fetchDone(fetchDone), .vecAddr(vecAddr)
  );

  rst_seq_ctrl uCtrl (
    .clk(clk), .porN(porN), .lvdLow(lvdLow), .wdgUnder(wdgUnder), .extReq(extReq),
    .pinLowSync(pinLowSync), .pulseDone(pulseDone), .dlyDone(dlyDone), .fetchDone(fetchDone),
    .strobe(strobe), .coreRst(coreRst), .padPullDown(padPullDown), .vecFetch(vecFetch),
    .causeQ(causeQ)
  );

  assign resetCause = causeQ;

  // R9: supply-low holds the block in a pulled-down reset
  a_r9_lvd_hold: assert property (@(posedge clk) disable iff (!porN)
    lvdLow |=> coreRst && padPullDown && (resetCause == 2'b10));

  // R8: a watchdog strobe without supply-low starts a pulled-down reset
  a_r8_wdg_start: assert property (@(posedge clk) disable iff (!porN)
    wdgUnder && !lvdLow |=> coreRst && padPullDown && (resetCause == 2'b01));

  // R4: vector address order during fetch
  a_r4_addr_first: assert property (@(posedge clk) disable iff (!porN)
    $rose(vecFetch) |-> vecAddr == VEC_ADDR);
  a_r4_addr_second: assert property (@(posedge clk) disable iff (!porN)
    vecFetch && $past(vecFetch) |-> vecAddr == VEC_ADDR + ADDR_W'(1));

endmodule

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NSHORT = 256;
  localparam int NLONG = 4096;
  localparam int WDGP = 16;

  typedef struct {
    logic [1:0] cause;
    int rstLen;
    int pdLen;
    string tag;
  } expT;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic tbLow = 1'b0;
  logic lvdLow = 1'b0;
  logic wdgUnder = 1'b0;
  logic longDelay = 1'b0;
  logic padLevel;
  logic padPullDown, coreRst, vecFetch;
  logic [15:0] vecAddr;
  logic [1:0] resetCause;

  expT expQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND open-drain pad
  assign padLevel = ~(tbLow | padPullDown);

  rst_sequencer u0 (
    .clk(clk), .porN(porN), .padIn(padLevel), .lvdLow(lvdLow), .wdgUnder(wdgUnder),
    .longDelay(longDelay), .padPullDown(padPullDown), .coreRst(coreRst), .vecFetch(vecFetch),
    .vecAddr(vecAddr), .resetCause(resetCause)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [1:0] c, input int r, input int p, input string t);
    expT e;
    e.cause = c; e.rstLen = r; e.pdLen = p; e.tag = t;
    expQ.push_back(e);
  endtask

  task automatic pulseWdg();
    @(negedge clk) wdgUnder = 1'b1;
    @(negedge clk) wdgUnder = 1'b0;
  endtask

  task automatic pinLow(input int k);
    @(negedge clk) tbLow = 1'b1;
    repeat (k) @(negedge clk);
    tbLow = 1'b0;
  endtask

  task automatic lvdHold(input int l);
    @(negedge clk) lvdLow = 1'b1;
    repeat (l) @(negedge clk);
    lvdLow = 1'b0;
  endtask

  task automatic waitIdle();
    wait (expQ.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  // monitor: measures each sequence and compares with the scoreboard
  initial begin
    @(posedge porN);
    forever begin
      int rstC;
      int pdC;
      int fC;
      bit addrOk;
      expT e;
      rstC = 0; pdC = 0; fC = 0; addrOk = 1'b1;
      forever begin
        @(negedge clk);
        if (vecFetch) begin
          if (vecAddr != 16'hFFFE + 16'(fC)) addrOk = 1'b0;
          if (padPullDown) pdC++;
          fC++;
        end else if (coreRst) begin
          rstC++;
          if (padPullDown) pdC++;
        end else if (fC > 0) begin
          break;
        end else if (padPullDown) begin
          pdC++;
        end
      end
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected sequence, reset cycles", rstC, 0);
      end else begin
        e = expQ.pop_front();
        check(resetCause == e.cause, e.tag, "cause code", int'(resetCause), int'(e.cause));
        check(rstC == e.rstLen, e.tag, "R2 reset cycles", rstC, e.rstLen);
        check(pdC == e.pdLen, e.tag, "R5 pull-down cycles", pdC, e.pdLen);
        check(fC == 2 && addrOk, "R4", "fetch cycles with FFFE/FFFF", fC, 2);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired, queue left", expQ.size(), 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(coreRst == 1'b1, "R1", "coreRst in reset", coreRst, 1);
    check(padPullDown == 1'b1, "R1", "padPullDown in reset", padPullDown, 1);
    check(resetCause == 2'b10, "R1", "cause in reset", resetCause, 2);
    pushExp(2'b10, 1 + NSHORT, 1 + NSHORT, "R1");
    @(posedge clk); #1 porN = 1'b1;
    waitIdle();

    // R8 watchdog, short delay
    pushExp(2'b01, WDGP + NSHORT, WDGP + NSHORT, "R8");
    pulseWdg();
    waitIdle();

    // R3 long delay, option flipped mid-delay is ignored
    longDelay = 1'b1;
    pushExp(2'b01, WDGP + NLONG, WDGP + NLONG, "R3");
    pulseWdg();
    repeat (100) @(negedge clk);
    longDelay = 1'b0;
    waitIdle();

    // R6 / R7 external pulse of minimum width
    pushExp(2'b00, 1 + NSHORT, NSHORT, "R6");
    pinLow(4);
    waitIdle();

    // R6 short pulse ignored, R11 cause held
    pinLow(3);
    begin
      bit seen;
      seen = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (coreRst || padPullDown || vecFetch) seen = 1'b1;
      end
      check(!seen, "R6", "3-cycle pulse caused reset", seen, 0);
    end
    check(resetCause == 2'b00, "R11", "cause held after sequence", resetCause, 0);

    // R7 longer external hold
    pushExp(2'b00, 7 + NSHORT, NSHORT, "R7");
    pinLow(10);
    waitIdle();

    // R9 supply-low held for 20 cycles
    pushExp(2'b10, 20 + NSHORT, 20 + NSHORT, "R9");
    lvdHold(20);
    waitIdle();

    // R10 restart by a second watchdog strobe during delay
    pushExp(2'b01, 100 + WDGP + NSHORT, 100 + WDGP + NSHORT, "R10");
    pulseWdg();
    repeat (98) @(negedge clk);
    pulseWdg();
    waitIdle();

    // R10 restart by supply-low during delay of a watchdog reset
    pushExp(2'b10, 50 + 5 + NSHORT, 50 + 5 + NSHORT, "R10");
    pulseWdg();
    repeat (48) @(negedge clk);
    lvdHold(5);
    waitIdle();

    // R10 priority: simultaneous watchdog and supply-low
    pushExp(2'b10, 1 + NSHORT, 1 + NSHORT, "R10");
    @(negedge clk) begin wdgUnder = 1'b1; lvdLow = 1'b1; end
    @(negedge clk) begin wdgUnder = 1'b0; lvdLow = 1'b0; end
    waitIdle();

    check(coreRst == 1'b0 && padPullDown == 1'b0, "R5", "outputs idle in run",
          int'(coreRst) + int'(padPullDown), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule